// File: doc/BRIEF.md
# Exception Entry Sequencer

This block makes the control-state update that happens when a core takes a trap. A trap is an exception, an interrupt or a debug breakpoint. The pipeline presents one trap per cycle on `trapValid` together with:

- the cause code and sub-code,
- the PC of the trapping instruction and its instruction word,
- a flag marking a translation-refill miss,
- the vector number chosen by the interrupt arbiter.

In the same clock edge the block selects one of three entry paths: normal, refill or debug. It writes the save registers that belong to that path and records the bad address and bad instruction where the cause calls for it. It clears the privilege level and the interrupt enable. One cycle after the request it raises a one-cycle `redirect` strobe with the handler address on `newPc`.

Handler addresses come from an entry base, a separate refill entry and a 3-bit spacing selector. When the selector is zero, every cause lands on the entry base. Otherwise each cause owns a slot of 2^(sel+2) bytes.

A small mode-load port lets the return-from-trap logic put back the privilege level, the interrupt enable and the translation-mode bits.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset:
  - `newPc` = 0x1C000000 and `redirect` = 0;
  - privilege 0, interrupt enable 0;
  - direct-translation 1, paged-translation 0;
  - both memory-type fields = 1;
  - all debug flags 0.
- R2: Slot spacing is 0 bytes when `vecSpacingSel` is 0 and (1 << sel) * 4 bytes otherwise.
- R3: An interrupt (cause code 0x00) taken while not in debug mode jumps to `entryBase + (64 + irqVec) * spacing`.
- R4: A normal-path trap does all of the following. A trap takes the normal path when it is neither the debug breakpoint nor an interrupt in debug mode, and is an interrupt or has `trapRefill` low.
  - It jumps to `entryBase + code * spacing`.
  - It writes the cause code and sub-code into the cause fields.
  - It saves the privilege level and IE into the normal saved-mode fields.
  - It copies `trapPc` into `retAddr`.
- R5: A refill-path trap (non-interrupt, non-debug, `trapRefill` high) does all of the following:
  - saves privilege and IE into the refill saved-mode fields;
  - forces direct-translation 1 and paged 0;
  - stores `trapPc >> 2` in `refRetWord`;
  - jumps to `refillBase`;
  - leaves `retAddr`, the cause fields and the normal saved-mode fields unchanged.
- R6: A debug breakpoint (cause code 0x3F) does all of the following:
  - sets the breakpoint flag and `dbgActive`;
  - writes 0x0C into `dbgCause`;
  - copies `trapPc` into `dbgRetAddr`;
  - jumps to `entryBase + 0x480`;
  - leaves `retAddr`, the cause fields, `badAddr` and `badInstr` unchanged.
- R7: An interrupt taken while `dbgActive` is 1 does all of the following:
  - sets `dbgIrqHit`;
  - copies `trapPc` into `dbgRetAddr`;
  - jumps to `entryBase + 0x480`;
  - leaves `retAddr` and the cause fields unchanged.
- R8: `badAddr` takes `trapPc` only for these cause codes: bound check 0x0A, syscall 0x0B, break 0x0C, illegal instruction 0x0D, privileged instruction 0x0E, FP disabled 0x0F and FP exception 0x12. Every other cause leaves it unchanged.
- R9: `badInstr` takes `trapInstr` on every non-debug trap except these three, which leave it unchanged:
  - interrupts (0x00);
  - fetch page-invalid (0x03);
  - address error with sub-code 0 (fetch side of 0x08).
- R10: Every trap clears privilege to 0 and IE to 0. `redirect` is 1 exactly in the cycle after a cycle with `trapValid` high and 0 otherwise.
- R11: `modeLd` loads privilege, IE, direct and paged bits in one cycle. A trap in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | A trap is taken this cycle |
| trapCode | input | 6 | Major cause code |
| trapSub | input | 9 | Cause sub-code |
| trapPc | input | ADDR_W | PC of the trapping instruction |
| trapInstr | input | 32 | Instruction word of the trapping instruction |
| trapRefill | input | 1 | Trap is a translation-refill miss |
| irqVec | input | VEC_W | Winning interrupt number from the arbiter |
| entryBase | input | ADDR_W | Base of the normal handler table |
| refillBase | input | ADDR_W | Refill handler address |
| vecSpacingSel | input | 3 | Handler slot spacing selector |
| modeLd | input | 1 | Load the current mode bits |
| modeLdPlv | input | 2 | Privilege level to load |
| modeLdIe | input | 1 | Interrupt enable to load |
| modeLdDa | input | 1 | Direct-translation bit to load |
| modeLdPg | input | 1 | Paged-translation bit to load |
| redirect | output | 1 | One-cycle strobe: fetch from newPc |
| newPc | output | ADDR_W | Handler address (reset PC after reset) |
| curPlv | output | 2 | Current privilege level |
| curIe | output | 1 | Current interrupt enable |
| transDirect | output | 1 | Direct-translation mode |
| transPaged | output | 1 | Paged-translation mode |
| fetchMat | output | 2 | Fetch memory type in direct mode |
| dataMat | output | 2 | Data memory type in direct mode |
| savedPlv | output | 2 | Privilege saved on normal entry |
| savedIe | output | 1 | IE saved on normal entry |
| refSavedPlv | output | 2 | Privilege saved on refill entry |
| refSavedIe | output | 1 | IE saved on refill entry |
| retAddr | output | ADDR_W | Return address of normal entry |
| refRetWord | output | ADDR_W-2 | Word return address of refill entry |
| badAddr | output | ADDR_W | Captured bad address |
| badInstr | output | 32 | Captured instruction word |
| causeCode | output | 6 | Recorded major cause |
| causeSub | output | 9 | Recorded sub-code |
| dbgRetAddr | output | ADDR_W | Return address of debug entry |
| dbgActive | output | 1 | Debug mode active |
| dbgBkptHit | output | 1 | Debug entered by breakpoint |
| dbgIrqHit | output | 1 | Interrupt arrived in debug mode |
| dbgCause | output | 6 | Debug cause code |

## Verification
The case hardest to reach from the ports is an interrupt that arrives in debug mode. Debug mode has no direct set, so the stimulus first takes a breakpoint and then, with no reset in between, presents an interrupt. It checks that the debug target and `dbgIrqHit` appear while the normal return address and cause stay put.

The refill path needs similar care: its forced translation bits equal the reset values. The bench therefore first loads the opposite mode through `modeLd`, so that the forcing is visible.

Every "unchanged" check compares a port value read just before the trap with the same port afterwards.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
  localparam int CODE_W = 6;
  localparam int SUB_W  = 9;

  localparam logic [CODE_W-1:0] CODE_IRQ       = 6'h00;
  localparam logic [CODE_W-1:0] CODE_FETCH_INV = 6'h03;
  localparam logic [CODE_W-1:0] CODE_ADDR_ERR  = 6'h08;
  localparam logic [CODE_W-1:0] CODE_BOUND     = 6'h0A;
  localparam logic [CODE_W-1:0] CODE_SYSCALL   = 6'h0B;
  localparam logic [CODE_W-1:0] CODE_BREAK     = 6'h0C;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL   = 6'h0D;
  localparam logic [CODE_W-1:0] CODE_PRIV      = 6'h0E;
  localparam logic [CODE_W-1:0] CODE_FP_OFF    = 6'h0F;
  localparam logic [CODE_W-1:0] CODE_FP_EXC    = 6'h12;
  localparam logic [CODE_W-1:0] CODE_DEBUG     = 6'h3F;
  localparam logic [CODE_W-1:0] DBG_BKPT_CAUSE = 6'h0C;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_NORMAL,
    PATH_REFILL,
    PATH_DEBUG
  } entry_path_e;

  // strobes from control to datapath
  typedef struct packed {
    entry_path_e path;
    logic        isIrq;
    logic        markBkpt;
    logic        markIrqDbg;
    logic        capBadAddr;
    logic        capBadInstr;
  } entry_ctl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              trapValid,
  input  logic [CODE_W-1:0] trapCode,
  input  logic [SUB_W-1:0]  trapSub,
  input  logic              trapRefill,
  input  logic              dbgActive,
  output entry_ctl_t        ctl
);
  logic isIrq;
  logic isBkpt;
  logic fetchSide;

  assign isIrq     = (trapCode == CODE_IRQ);
  assign isBkpt    = (trapCode == CODE_DEBUG);
  assign fetchSide = (trapCode == CODE_FETCH_INV) ||
                     ((trapCode == CODE_ADDR_ERR) && (trapSub == '0));

  always_comb begin
    ctl = '0;
    if (trapValid) begin
      if (isBkpt) begin
        ctl.path     = PATH_DEBUG;
        ctl.markBkpt = 1'b1;
      end else if (isIrq && dbgActive) begin
        ctl.path       = PATH_DEBUG;
        ctl.markIrqDbg = 1'b1;
      end else begin
        ctl.path  = (trapRefill && !isIrq) ? PATH_REFILL : PATH_NORMAL;
        ctl.isIrq = isIrq;
        ctl.capBadAddr = (trapCode == CODE_BOUND)   || (trapCode == CODE_SYSCALL) ||
                         (trapCode == CODE_BREAK)   || (trapCode == CODE_ILLEGAL) ||
                         (trapCode == CODE_PRIV)    || (trapCode == CODE_FP_OFF)  ||
                         (trapCode == CODE_FP_EXC);
        ctl.capBadInstr = !(isIrq || fetchSide);
      end
    end
  end
endmodule

// File: rtl/exc_entry_dp.sv
`timescale 1ns/1ps
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 64,
  parameter int                VEC_W     = 4,
  parameter int                INT_BASE  = 64,
  parameter logic [ADDR_W-1:0] RESET_PC  = 'h1C00_0000,
  parameter logic [ADDR_W-1:0] DEBUG_OFS = 'h480
) (
  input  logic              clk,
  input  logic              rstN,
  input  entry_ctl_t        ctl,
  input  logic [CODE_W-1:0] trapCode,
  input  logic [SUB_W-1:0]  trapSub,
  input  logic [ADDR_W-1:0] trapPc,
  input  logic [31:0]       trapInstr,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic [ADDR_W-1:0] entryBase,
  input  logic [ADDR_W-1:0] refillBase,
  input  logic [2:0]        vecSpacingSel,
  input  logic              modeLd,
  input  logic [1:0]        modeLdPlv,
  input  logic              modeLdIe,
  input  logic              modeLdDa,
  input  logic              modeLdPg,
  output logic              redirect,
  output logic [ADDR_W-1:0] newPc,
  output logic [1:0]        curPlv,
  output logic              curIe,
  output logic              transDirect,
  output logic              transPaged,
  output logic [1:0]        fetchMat,
  output logic [1:0]        dataMat,
  output logic [1:0]        savedPlv,
  output logic              savedIe,
  output logic [1:0]        refSavedPlv,
  output logic              refSavedIe,
  output logic [ADDR_W-1:0] retAddr,
  output logic [ADDR_W-3:0] refRetWord,
  output logic [ADDR_W-1:0] badAddr,
  output logic [31:0]       badInstr,
  output logic [CODE_W-1:0] causeCode,
  output logic [SUB_W-1:0]  causeSub,
  output logic [ADDR_W-1:0] dbgRetAddr,
  output logic              dbgActive,
  output logic              dbgBkptHit,
  output logic              dbgIrqHit,
  output logic [CODE_W-1:0] dbgCause
);
  localparam int IDX_RAW = $clog2(INT_BASE + (1 << VEC_W));
  localparam int IDX_W   = (IDX_RAW > CODE_W) ? IDX_RAW : CODE_W;

  logic [IDX_W-1:0]  slotIdx;
  logic [ADDR_W-1:0] slotOfs;
  logic [ADDR_W-1:0] target;
  logic              taking;

  assign taking  = (ctl.path != PATH_NONE);
  assign slotIdx = ctl.isIrq ? (IDX_W'(INT_BASE) + IDX_W'(irqVec)) : IDX_W'(trapCode);
  assign slotOfs = (vecSpacingSel == 3'd0) ? '0
                 : (ADDR_W'(slotIdx) << ({1'b0, vecSpacingSel} + 4'd2));

  always_comb begin
    case (ctl.path)
      PATH_REFILL: target = refillBase;
      PATH_DEBUG:  target = entryBase + DEBUG_OFS;
      default:     target = entryBase + slotOfs;
    endcase
  end

  // redirect strobe and handler address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirect <= 1'b0;
      newPc    <= RESET_PC;
    end else begin
      redirect <= taking;
      if (taking) newPc <= target;
    end
  end

  // current mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPlv      <= 2'd0;
      curIe       <= 1'b0;
      transDirect <= 1'b1;
      transPaged  <= 1'b0;
      fetchMat    <= 2'd1;
      dataMat     <= 2'd1;
    end else if (taking) begin
      curPlv <= 2'd0;
      curIe  <= 1'b0;
      if (ctl.path == PATH_REFILL) begin
        transDirect <= 1'b1;
        transPaged  <= 1'b0;
      end
    end else if (modeLd) begin
      curPlv      <= modeLdPlv;
      curIe       <= modeLdIe;
      transDirect <= modeLdDa;
      transPaged  <= modeLdPg;
    end
  end

  // normal and refill save state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPlv    <= '0;
      savedIe     <= 1'b0;
      refSavedPlv <= '0;
      refSavedIe  <= 1'b0;
      retAddr     <= '0;
      refRetWord  <= '0;
      causeCode   <= '0;
      causeSub    <= '0;
      badAddr     <= '0;
      badInstr    <= '0;
    end else begin
      if (ctl.path == PATH_NORMAL) begin
        savedPlv  <= curPlv;
        savedIe   <= curIe;
        retAddr   <= trapPc;
        causeCode <= trapCode;
        causeSub  <= trapSub;
      end
      if (ctl.path == PATH_REFILL) begin
        refSavedPlv <= curPlv;
        refSavedIe  <= curIe;
        refRetWord  <= trapPc[ADDR_W-1:2];
      end
      if (ctl.capBadAddr)  badAddr  <= trapPc;
      if (ctl.capBadInstr) badInstr <= trapInstr;
    end
  end

  // debug state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgRetAddr <= '0;
      dbgActive  <= 1'b0;
      dbgBkptHit <= 1'b0;
      dbgIrqHit  <= 1'b0;
      dbgCause   <= '0;
    end else if (ctl.path == PATH_DEBUG) begin
      dbgRetAddr <= trapPc;
      dbgActive  <= 1'b1;
      if (ctl.markBkpt) begin
        dbgBkptHit <= 1'b1;
        dbgCause   <= DBG_BKPT_CAUSE;
      end
      if (ctl.markIrqDbg) dbgIrqHit <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 64,
  parameter int                VEC_W     = 4,
  parameter int                INT_BASE  = 64,
  parameter logic [ADDR_W-1:0] RESET_PC  = 'h1C00_0000,
  parameter logic [ADDR_W-1:0] DEBUG_OFS = 'h480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapValid,
  input  logic [5:0]        trapCode,
  input  logic [8:0]        trapSub,
  input  logic [ADDR_W-1:0] trapPc,
  input  logic [31:0]       trapInstr,
  input  logic              trapRefill,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic [ADDR_W-1:0] entryBase,
  input  logic [ADDR_W-1:0] refillBase,
  input  logic [2:0]        vecSpacingSel,
  input  logic              modeLd,
  input  logic [1:0]        modeLdPlv,
  input  logic              modeLdIe,
  input  logic              modeLdDa,
  input  logic              modeLdPg,
  output logic              redirect,
  output logic [ADDR_W-1:0] newPc,
  output logic [1:0]        curPlv,
  output logic              curIe,
  output logic              transDirect,
  output logic              transPaged,
  output logic [1:0]        fetchMat,
  output logic [1:0]        dataMat,
  output logic [1:0]        savedPlv,
  output logic              savedIe,
  output logic [1:0]        refSavedPlv,
  output logic              refSavedIe,
  output logic [ADDR_W-1:0] retAddr,
  output logic [ADDR_W-3:0] refRetWord,
  output logic [ADDR_W-1:0] badAddr,
  output logic [31:0]       badInstr,
  output logic [5:0]        causeCode,
  output logic [8:0]        causeSub,
  output logic [ADDR_W-1:0] dbgRetAddr,
  output logic              dbgActive,
  output logic              dbgBkptHit,
  output logic              dbgIrqHit,
  output logic [5:0]        dbgCause
);
  entry_ctl_t ctl;

  exc_entry_ctrl u_ctrl (
    .trapValid (trapValid),
    .trapCode  (trapCode),
    .trapSub   (trapSub),
    .trapRefill(trapRefill),
    .dbgActive (dbgActive),
    .ctl       (ctl)
  );

  exc_entry_dp #(
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .INT_BASE (INT_BASE),
    .RESET_PC (RESET_PC),
    .DEBUG_OFS(DEBUG_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .trapCode(trapCode), .trapSub(trapSub), .trapPc(trapPc), .trapInstr(trapInstr),
    .irqVec(irqVec), .entryBase(entryBase), .refillBase(refillBase),
    .vecSpacingSel(vecSpacingSel),
    .modeLd(modeLd), .modeLdPlv(modeLdPlv), .modeLdIe(modeLdIe),
    .modeLdDa(modeLdDa), .modeLdPg(modeLdPg),
    .redirect(redirect), .newPc(newPc), .curPlv(curPlv), .curIe(curIe),
    .transDirect(transDirect), .transPaged(transPaged),
    .fetchMat(fetchMat), .dataMat(dataMat),
    .savedPlv(savedPlv), .savedIe(savedIe),
    .refSavedPlv(refSavedPlv), .refSavedIe(refSavedIe),
    .retAddr(retAddr), .refRetWord(refRetWord),
    .badAddr(badAddr), .badInstr(badInstr),
    .causeCode(causeCode), .causeSub(causeSub),
    .dbgRetAddr(dbgRetAddr), .dbgActive(dbgActive),
    .dbgBkptHit(dbgBkptHit), .dbgIrqHit(dbgIrqHit), .dbgCause(dbgCause)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
`timescale 1ns/1ps
module exc_entry_seq_chk
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] DEBUG_OFS = 'h480
) (
  input logic              clk,
  input logic              rstN,
  input logic              trapValid,
  input logic [5:0]        trapCode,
  input logic [ADDR_W-1:0] trapPc,
  input logic              trapRefill,
  input logic [ADDR_W-1:0] entryBase,
  input logic [ADDR_W-1:0] refillBase,
  input logic              redirect,
  input logic [ADDR_W-1:0] newPc,
  input logic [1:0]        curPlv,
  input logic              curIe,
  input logic              transDirect,
  input logic              transPaged,
  input logic [ADDR_W-1:0] retAddr,
  input logic [ADDR_W-1:0] dbgRetAddr,
  input logic              dbgActive,
  input logic              dbgIrqHit
);
  p_redirect_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> redirect);

  p_redirect_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !redirect);

  p_mode_cleared_r10: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (curPlv == 2'd0) && !curIe);

  p_debug_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapCode == CODE_DEBUG) |=>
      dbgActive && (newPc == $past(entryBase) + DEBUG_OFS) && (dbgRetAddr == $past(trapPc)));

  p_irq_in_debug_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapCode == CODE_IRQ && dbgActive) |=>
      dbgIrqHit && (newPc == $past(entryBase) + DEBUG_OFS));

  p_refill_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapRefill && trapCode != CODE_IRQ && trapCode != CODE_DEBUG) |=>
      transDirect && !transPaged && (newPc == $past(refillBase)));

  p_normal_ret_r4: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapCode != CODE_DEBUG && !(trapCode == CODE_IRQ && dbgActive) &&
     !(trapRefill && trapCode != CODE_IRQ)) |=> (retAddr == $past(trapPc)));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W), .DEBUG_OFS(DEBUG_OFS)) u_chk (.*);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  localparam int ADDR_W = 64;
  localparam int VEC_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              trapValid = 1'b0;
  logic [5:0]        trapCode = '0;
  logic [8:0]        trapSub = '0;
  logic [ADDR_W-1:0] trapPc = '0;
  logic [31:0]       trapInstr = '0;
  logic              trapRefill = 1'b0;
  logic [VEC_W-1:0]  irqVec = '0;
  logic [ADDR_W-1:0] entryBase  = 64'h0000_0000_9000_0000;
  logic [ADDR_W-1:0] refillBase = 64'h0000_0000_A000_1000;
  logic [2:0]        vecSpacingSel = '0;
  logic              modeLd = 1'b0;
  logic [1:0]        modeLdPlv = '0;
  logic              modeLdIe = 1'b0, modeLdDa = 1'b0, modeLdPg = 1'b0;
  logic              redirect;
  logic [ADDR_W-1:0] newPc, retAddr, badAddr, dbgRetAddr;
  logic [ADDR_W-3:0] refRetWord;
  logic [1:0]        curPlv, fetchMat, dataMat, savedPlv, refSavedPlv;
  logic              curIe, transDirect, transPaged, savedIe, refSavedIe;
  logic [31:0]       badInstr;
  logic [5:0]        causeCode, dbgCause;
  logic [8:0]        causeSub;
  logic              dbgActive, dbgBkptHit, dbgIrqHit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exc_entry_seq u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] slotPc(input logic [63:0] base, input int idx, input int sel);
    if (sel == 0) return base;
    return base + 64'(idx) * (64'(1) << sel) * 64'd4;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive one trap for one cycle; returns at the negedge after it is taken
  task automatic fire(input logic [5:0] code, input logic [8:0] sub, input logic [63:0] pc,
                      input logic [31:0] instr, input logic refill, input logic [3:0] vec);
    @(negedge clk);
    trapValid = 1'b1; trapCode = code; trapSub = sub; trapPc = pc;
    trapInstr = instr; trapRefill = refill; irqVec = vec;
    @(negedge clk);
    trapValid = 1'b0; trapRefill = 1'b0;
  endtask

  task automatic loadMode(input logic [1:0] plv, input logic ie, input logic da, input logic pg);
    @(negedge clk);
    modeLd = 1'b1; modeLdPlv = plv; modeLdIe = ie; modeLdDa = da; modeLdPg = pg;
    @(negedge clk);
    modeLd = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 newPc", newPc, 64'h1C00_0000);
    chk("R1 redirect", 64'(redirect), 0);
    chk("R1 plv/ie", {curPlv, curIe}, 0);
    chk("R1 da/pg", {transDirect, transPaged}, 2'b10);
    chk("R1 mat", {fetchMat, dataMat}, 4'b0101);
    chk("R1 dbg", {dbgActive, dbgBkptHit, dbgIrqHit}, 0);
  endtask

  task automatic testModeLoad();
    loadMode(2'd3, 1'b1, 1'b0, 1'b1);
    chk("R11 load", {curPlv, curIe, transDirect, transPaged}, {2'd3, 1'b1, 1'b0, 1'b1});
  endtask

  task automatic testSyscall();
    vecSpacingSel = 3'd0;
    fire(6'h0B, 9'd5, 64'h1000_0040, 32'hCAFE_0001, 1'b0, 4'd0);
    chk("R4 R2 target sel0", newPc, entryBase);
    chk("R10 redirect", 64'(redirect), 1);
    chk("R10 plv/ie cleared", {curPlv, curIe}, 0);
    chk("R4 saved mode", {savedPlv, savedIe}, {2'd3, 1'b1});
    chk("R4 retAddr", retAddr, 64'h1000_0040);
    chk("R4 cause", {causeCode, causeSub}, {6'h0B, 9'd5});
    chk("R8 badAddr syscall", badAddr, 64'h1000_0040);
    chk("R9 badInstr syscall", 64'(badInstr), 64'hCAFE_0001);
    @(negedge clk);
    chk("R10 redirect single", 64'(redirect), 0);
  endtask

  task automatic testPageLoad();
    logic [63:0] oldBad;
    oldBad = badAddr;
    vecSpacingSel = 3'd3;
    fire(6'h01, 9'd0, 64'h1000_0080, 32'h1234_5678, 1'b0, 4'd0);
    chk("R2 R4 target sel3", newPc, slotPc(entryBase, 1, 3));
    chk("R8 badAddr kept", badAddr, oldBad);
    chk("R9 badInstr load", 64'(badInstr), 64'h1234_5678);
  endtask

  task automatic testAddrErr();
    fire(6'h08, 9'd0, 64'h1000_00C0, 32'hDEAD_0000, 1'b0, 4'd0);
    chk("R9 fetch adderr keeps", 64'(badInstr), 64'h1234_5678);
    chk("R2 R4 target adderr", newPc, slotPc(entryBase, 8, 3));
    fire(6'h08, 9'd1, 64'h1000_0100, 32'hBEEF_0001, 1'b0, 4'd0);
    chk("R9 mem adderr latches", 64'(badInstr), 64'hBEEF_0001);
    fire(6'h12, 9'd0, 64'h1000_0140, 32'h0, 1'b0, 4'd0);
    chk("R8 fp exc badAddr", badAddr, 64'h1000_0140);
  endtask

  task automatic testIrq();
    logic [31:0] oldInstr;
    oldInstr = badInstr;
    vecSpacingSel = 3'd1;
    fire(6'h00, 9'd0, 64'h1000_0200, 32'h5555_AAAA, 1'b1, 4'd2);
    chk("R3 irq target", newPc, slotPc(entryBase, 66, 1));
    chk("R9 irq keeps badInstr", 64'(badInstr), 64'(oldInstr));
    chk("R3 irq cause", 64'(causeCode), 0);
    chk("R4 irq retAddr", retAddr, 64'h1000_0200);
  endtask

  task automatic testRefill();
    logic [63:0] oldRet;
    logic [5:0]  oldCause;
    logic [2:0]  oldSaved;
    loadMode(2'd2, 1'b1, 1'b0, 1'b1);
    oldRet = retAddr; oldCause = causeCode; oldSaved = {savedPlv, savedIe};
    fire(6'h01, 9'd0, 64'h2000_0108, 32'h7777_0000, 1'b1, 4'd0);
    chk("R5 target", newPc, refillBase);
    chk("R5 saved", {refSavedPlv, refSavedIe}, {2'd2, 1'b1});
    chk("R5 da/pg", {transDirect, transPaged}, 2'b10);
    chk("R5 word", 64'(refRetWord), 64'h2000_0108 >> 2);
    chk("R5 retAddr kept", retAddr, oldRet);
    chk("R5 cause kept", 64'(causeCode), 64'(oldCause));
    chk("R5 normal save kept", 64'({savedPlv, savedIe}), 64'(oldSaved));
    chk("R10 refill plv/ie", {curPlv, curIe}, 0);
  endtask

  task automatic testDebug();
    logic [63:0] oldRet, oldBad;
    logic [5:0]  oldCause;
    logic [31:0] oldInstr;
    oldRet = retAddr; oldCause = causeCode; oldBad = badAddr; oldInstr = badInstr;
    fire(6'h3F, 9'd0, 64'h3000_0010, 32'h9999_9999, 1'b0, 4'd0);
    chk("R6 target", newPc, entryBase + 64'h480);
    chk("R6 flags", {dbgActive, dbgBkptHit, dbgIrqHit}, 3'b110);
    chk("R6 dbgCause", 64'(dbgCause), 64'h0C);
    chk("R6 dbgRetAddr", dbgRetAddr, 64'h3000_0010);
    chk("R6 retAddr kept", retAddr, oldRet);
    chk("R6 cause kept", 64'(causeCode), 64'(oldCause));
    chk("R6 bad kept", {badAddr, badInstr}, {oldBad, oldInstr});
    // interrupt while debug mode is active
    fire(6'h00, 9'd0, 64'h3000_0020, 32'h0, 1'b0, 4'd5);
    chk("R7 target", newPc, entryBase + 64'h480);
    chk("R7 irq flag", 64'(dbgIrqHit), 1);
    chk("R7 dbgRetAddr", dbgRetAddr, 64'h3000_0020);
    chk("R7 retAddr kept", retAddr, oldRet);
    chk("R7 cause kept", 64'(causeCode), 64'(oldCause));
  endtask

  task automatic testPrecedence();
    @(negedge clk);
    modeLd = 1'b1; modeLdPlv = 2'd3; modeLdIe = 1'b1; modeLdDa = 1'b0; modeLdPg = 1'b1;
    trapValid = 1'b1; trapCode = 6'h0D; trapSub = 0; trapPc = 64'h4000_0000; trapRefill = 1'b0;
    @(negedge clk);
    modeLd = 1'b0; trapValid = 1'b0;
    chk("R11 trap wins", {curPlv, curIe}, 0);
    chk("R11 mode bits not loaded", {transDirect, transPaged}, 2'b10);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testModeLoad();
    testSyscall();
    testPageLoad();
    testAddrErr();
    testIrq();
    testRefill();
    doReset();
    testDebug();
    doReset();
    testPrecedence();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule